// File: doc/BRIEF.md
# Clearable Interval Timebase

This block is a free-running binary prescaler that counts enabled ticks of a divided oscillator clock. It has no run or stop control: while ticks arrive it keeps counting. Its raw count bits leave the block as taps for a downstream watchdog. A selected count bit raises a sticky interval flag each time it carries, and the flag can drive an interrupt request.

Several independent events return the count to zero:
- entry to a low-power (stop or standby) mode;
- a switch from the main clock to the PLL clock;
- a switch from the main clock to the subclock;
- a software write of 0 to the clear control.

Because of this, every interval is measured from the most recent clear. The same counter can therefore time an oscillator stabilization wait. A low-power entry also forces the interval flag low at once, so that the wait starts from a clean flag.

A clear request is a single-cycle pulse. It takes effect on the next enabled edge and replaces the increment there. A small two-state clear controller holds a request that arrives between ticks until the next tick.

Top module: `ivl_timebase`

## Requirements
- R1: On a clock edge with `tick` high and no clear in force, `taps` increments by 1, wrapping modulo 2^CNT_W. On an edge with `tick` low, `taps` holds its value.
- R2: While `rst_n` is low (asynchronous, active low), `taps` is 0, `flag` is 0 and `irq` is 0.
- R3: Each of these is a clear request: `lp_enter`, `pll_sw`, `sub_sw`, or `swclr_wr` high with `swclr_wdata` = 0. A clear request present at an edge with `tick` high makes `taps` 0 at that edge, in place of the increment.
- R4: A clear request at an edge with `tick` low is remembered while `taps` holds. At the next edge with `tick` high, `taps` becomes 0 and not its value plus one. After that edge, counting resumes normally.
- R5: `ivl_sel` picks the interval. Code s selects the carry out of bit CNT_W-7+2*s, which is bits 11, 13, 15 and 17 for codes 0 to 3 at CNT_W = 18. `flag` is set at the ticked edge where count bits [that bit:0] are all ones. It is therefore first set 2^(CNT_W-6+2*s) ticks after a clear, and not earlier.
- R6: `flag` is sticky. It is cleared only by `flg_wr` with `flg_wdata` = 0, and a write with `flg_wdata` = 1 has no effect. A selected carry at the same edge as a clearing write wins, and `flag` stays 1.
- R7: `lp_enter` forces `flag` to 0 at the same edge, whether or not `tick` is high.
- R8: `irq` is high exactly when `flag` and `ie` are both high.
- R9: `swclr_rd` always reads 1. A write of 1 to the clear control (`swclr_wr` with `swclr_wdata` = 1) has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Count enable from the divided oscillator |
| lp_enter | input | 1 | Pulse on entry to stop or standby mode |
| pll_sw | input | 1 | Pulse on a main-to-PLL clock switch |
| sub_sw | input | 1 | Pulse on a main-to-subclock switch |
| swclr_wr | input | 1 | Software write strobe for the clear control |
| swclr_wdata | input | 1 | Data written to the clear control (0 clears the count) |
| ivl_sel | input | 2 | Interval select code |
| flg_wr | input | 1 | Software write strobe for the interval flag |
| flg_wdata | input | 1 | Data written to the flag (0 clears it) |
| ie | input | 1 | Interrupt enable |
| flag | output | 1 | Sticky interval flag |
| irq | output | 1 | Interrupt request |
| taps | output | CNT_W | Raw counter bits for downstream use |
| swclr_rd | output | 1 | Read-back value of the clear control |

## Verification
A clear controller stuck in its waiting state would show on `taps` at the very next tick. The count would read 0 again where it should have read one more, and it would keep doing so on every following tick. A lost pending request would show at the first tick after the pulse as the old value plus one instead of 0. Counter or tap-selection errors are visible only through `flag`, so they show up as an interval length that is wrong by a power of two. The bench measures the exact tick count to the first flag for every select code so that such an error is caught within one interval.

// File: rtl/ivl_tb_pkg.sv
package ivl_tb_pkg;

    // Clear controller states
    typedef enum logic {
        ST_COUNT    = 1'b0,   // no clear outstanding
        ST_CLR_WAIT = 1'b1    // clear seen between ticks, waiting for a tick
    } clr_state_e;

    // Bit whose carry-out feeds interval tap i of n taps
    function automatic int tap_bit(input int cnt_w, input int n_taps, input int i);
        return cnt_w - 1 - 2 * (n_taps - 1 - i);
    endfunction

endpackage

// File: rtl/ivl_clr_fsm.sv
module ivl_clr_fsm
    import ivl_tb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic clr_now
);

    clr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT:    if (req && !tick) state_d = ST_CLR_WAIT;
            ST_CLR_WAIT: if (tick)         state_d = ST_COUNT;
            default:                       state_d = ST_COUNT;
        endcase
    end

    // outputs: a clear is applied only on a ticked edge
    always_comb begin
        clr_now = 1'b0;
        unique case (state_q)
            ST_COUNT:    clr_now = tick && req;
            ST_CLR_WAIT: clr_now = tick;
            default:     clr_now = 1'b0;
        endcase
    end

endmodule

// File: rtl/ivl_count.sv
module ivl_count
    import ivl_tb_pkg::*;
#(
    parameter int CNT_W  = 18,
    parameter int N_TAPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr_now,
    output logic [CNT_W-1:0]  cnt,
    output logic [N_TAPS-1:0] carry
);

    logic inc;
    assign inc = tick && !clr_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr_now) cnt <= '0;
        else if (inc)     cnt <= cnt + 1'b1;
    end

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int B = tap_bit(CNT_W, N_TAPS, i);
        assign carry[i] = inc && (&cnt[B:0]);
    end

endmodule

// File: rtl/ivl_flag.sv
module ivl_flag #(
    parameter int N_TAPS = 4,
    localparam int SEL_W = $clog2(N_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAPS-1:0] carry,
    input  logic [SEL_W-1:0]  sel,
    input  logic              lp_enter,
    input  logic              flg_clr,
    output logic              flag
);

    logic hit, flag_d;
    assign hit = carry[sel];

    // priority: low-power entry, then carry, then software clear
    always_comb begin
        flag_d = flag;
        if (lp_enter)     flag_d = 1'b0;
        else if (hit)     flag_d = 1'b1;
        else if (flg_clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= flag_d;
    end

endmodule

// File: rtl/ivl_timebase.sv
module ivl_timebase #(
    parameter int CNT_W  = 18,
    localparam int N_TAPS = 4,
    localparam int SEL_W  = $clog2(N_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lp_enter,
    input  logic             pll_sw,
    input  logic             sub_sw,
    input  logic             swclr_wr,
    input  logic             swclr_wdata,
    input  logic [SEL_W-1:0] ivl_sel,
    input  logic             flg_wr,
    input  logic             flg_wdata,
    input  logic             ie,
    output logic             flag,
    output logic             irq,
    output logic [CNT_W-1:0] taps,
    output logic             swclr_rd
);

    logic              clr_req, clr_now;
    logic [N_TAPS-1:0] carry;

    // only a written 0 clears; a written 1 is dropped
    assign clr_req = lp_enter || pll_sw || sub_sw || (swclr_wr && !swclr_wdata);

    ivl_clr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .req     (clr_req),
        .clr_now (clr_now)
    );

    ivl_count #(.CNT_W(CNT_W), .N_TAPS(N_TAPS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr_now (clr_now),
        .cnt     (taps),
        .carry   (carry)
    );

    ivl_flag #(.N_TAPS(N_TAPS)) u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry    (carry),
        .sel      (ivl_sel),
        .lp_enter (lp_enter),
        .flg_clr  (flg_wr && !flg_wdata),
        .flag     (flag)
    );

    assign irq      = flag && ie;
    assign swclr_rd = 1'b1;

endmodule

// File: rtl/ivl_timebase_chk.sv
module ivl_timebase_chk #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             lp_enter,
    input logic             pll_sw,
    input logic             sub_sw,
    input logic             swclr_wr,
    input logic             swclr_wdata,
    input logic             flg_wr,
    input logic             flg_wdata,
    input logic             ie,
    input logic             flag,
    input logic             irq,
    input logic [CNT_W-1:0] taps
);

    // R1: without a tick the count never moves
    a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(taps));

    // R3: a clear request on a ticked edge zeroes the count
    a_r3_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (lp_enter || pll_sw || sub_sw || (swclr_wr && !swclr_wdata)))
        |=> (taps == '0));

    // R5: the flag only rises on a ticked edge
    a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick));

    // R6: the flag stays set unless cleared by software or low-power entry
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !lp_enter && !(flg_wr && !flg_wdata)) |=> flag);

    // R7: low-power entry drops the flag at that edge
    a_r7_lp_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        lp_enter |=> !flag);

    // R8: an interrupt request only appears while enabled
    a_r8_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie && flag));

endmodule

bind ivl_timebase ivl_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .lp_enter    (lp_enter),
    .pll_sw      (pll_sw),
    .sub_sw      (sub_sw),
    .swclr_wr    (swclr_wr),
    .swclr_wdata (swclr_wdata),
    .flg_wr      (flg_wr),
    .flg_wdata   (flg_wdata),
    .ie          (ie),
    .flag        (flag),
    .irq         (irq),
    .taps        (taps)
);

// File: tb/sim_ivl_timebase.sv
`timescale 1ns/1ps
module sim_ivl_timebase;

    localparam int CW = 10;   // taps 3,5,7,9 -> intervals 16,64,256,1024 ticks

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, lp_enter = 1'b0, pll_sw = 1'b0, sub_sw = 1'b0;
    logic          swclr_wr = 1'b0, swclr_wdata = 1'b0;
    logic [1:0]    ivl_sel = 2'd0;
    logic          flg_wr = 1'b0, flg_wdata = 1'b0, ie = 1'b0;
    logic          flag, irq, swclr_rd;
    logic [CW-1:0] taps;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ivl_timebase #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lp_enter(lp_enter),
        .pll_sw(pll_sw), .sub_sw(sub_sw), .swclr_wr(swclr_wr),
        .swclr_wdata(swclr_wdata), .ivl_sel(ivl_sel), .flg_wr(flg_wr),
        .flg_wdata(flg_wdata), .ie(ie), .flag(flag), .irq(irq),
        .taps(taps), .swclr_rd(swclr_rd)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] n;
    } vec_t;

    localparam int VEC_N = 4;
    localparam vec_t VECS [VEC_N] = '{
        '{2'd0, 16'd16}, '{2'd1, 16'd64}, '{2'd2, 16'd256}, '{2'd3, 16'd1024}
    };

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // one clock edge; pulse inputs are dropped after it
    task automatic step(input logic t);
        tick = t;
        @(negedge clk);
        tick = 1'b0; lp_enter = 1'b0; pll_sw = 1'b0; sub_sw = 1'b0;
        swclr_wr = 1'b0; flg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset taps", int'(taps), 0);
        chk("R2 reset flag", int'(flag), 0);
        chk("R2 reset irq", int'(irq), 0);
        chk("R9 clear readback", int'(swclr_rd), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 count and hold
        repeat (5) step(1'b1);
        chk("R1 five ticks", int'(taps), 5);
        repeat (3) step(1'b0);
        chk("R1 hold without tick", int'(taps), 5);

        // R9 write of 1 ignored
        swclr_wr = 1'b1; swclr_wdata = 1'b1; step(1'b1);
        chk("R9 write 1 no clear", int'(taps), 6);
        // R3 software clear
        swclr_wr = 1'b1; swclr_wdata = 1'b0; step(1'b1);
        chk("R3 software clear", int'(taps), 0);

        // R4 pending clear from a PLL switch between ticks
        repeat (3) step(1'b1);
        pll_sw = 1'b1; step(1'b0);
        chk("R4 hold while pending", int'(taps), 3);
        step(1'b0); step(1'b0);
        chk("R4 still pending", int'(taps), 3);
        step(1'b1);
        chk("R4 pending applied", int'(taps), 0);
        step(1'b1);
        chk("R4 counting resumes", int'(taps), 1);

        // R3 subclock switch and low-power entry with tick
        step(1'b1);
        sub_sw = 1'b1; step(1'b1);
        chk("R3 subclock clear", int'(taps), 0);
        step(1'b1);
        lp_enter = 1'b1; step(1'b1);
        chk("R3 low-power clear", int'(taps), 0);

        // R5 table walk: ticks to first flag, tick every other cycle
        for (int v = 0; v < VEC_N; v++) begin
            int n;
            ivl_sel = VECS[v].sel;
            swclr_wr = 1'b1; swclr_wdata = 1'b0; flg_wr = 1'b1; flg_wdata = 1'b0;
            step(1'b1);
            n = 0;
            while (!flag && n < 3000) begin
                step(1'b1);
                n++;
                step(1'b0);
            end
            chk($sformatf("R5 interval sel=%0d", v), n, int'(VECS[v].n));
        end

        // R6 software writes to flag
        flg_wr = 1'b1; flg_wdata = 1'b1; step(1'b0);
        chk("R6 write 1 keeps flag", int'(flag), 1);
        flg_wr = 1'b1; flg_wdata = 1'b0; step(1'b0);
        chk("R6 write 0 clears flag", int'(flag), 0);

        // R6 carry beats a clearing write
        ivl_sel = 2'd0;
        swclr_wr = 1'b1; swclr_wdata = 1'b0; step(1'b1);
        repeat (15) step(1'b1);
        chk("R5 no early flag", int'(flag), 0);
        flg_wr = 1'b1; flg_wdata = 1'b0; step(1'b1);
        chk("R6 carry wins over clear", int'(flag), 1);

        // R8 interrupt gating
        chk("R8 irq off when disabled", int'(irq), 0);
        ie = 1'b1; step(1'b0);
        chk("R8 irq on", int'(irq), 1);

        // R7 low-power entry without tick
        lp_enter = 1'b1; step(1'b0);
        chk("R7 flag dropped", int'(flag), 0);
        chk("R8 irq follows flag", int'(irq), 0);
        chk("R4 low-power clear pending", int'(taps), 16);
        step(1'b1);
        chk("R4 low-power clear applied", int'(taps), 0);

        // R2 reset mid-run
        repeat (7) step(1'b1);
        rst_n = 1'b0;
        #1;
        chk("R2 async reset taps", int'(taps), 0);
        chk("R2 async reset flag", int'(flag), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule